// File: doc/BRIEF.md
# I2C Command-Echo Slave

This block is an I2C slave that collects one-byte commands from the master and answers them later. In a write transaction the master sends one or more command bytes, and the slave places each one in a small queue. The master then issues a repeated START with the read address. The slave replays the queue: for each stored command it sends the command byte itself, then one data byte.

The data byte for a command comes from local registers through a simple request/acknowledge handshake. When a command is taken from the queue for transmission, the block raises a request carrying the command as the register address. It latches the returned byte for the data slot that follows.

The bus pins pass through a synchronizer and a two-sample agreement filter before edge detection. SDA is driven through an active-high pull-down enable.

Top module: `cmd_echo_i2c_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x12 (address byte bits 7:1, bit 0 is R/W with 1 meaning read). For any other address it leaves SDA released in the acknowledge slot and ignores the bus until the next START.
- R2: While fewer than 8 commands are stored, each command byte of a write transaction is acknowledged and queued.
- R3: A command byte arriving when 8 are already stored is not acknowledged and is discarded; the stored count never exceeds 8.
- R4: After a repeated START, the address 0x12 with R/W set to 1 is acknowledged.
- R5: In a read, each queued command is returned as the command byte followed by its data byte. Pairs come back in the order the commands were received, most significant bit first. The slave changes SDA only while SCL is low.
- R6: The data byte equals `reg_data` taken when `reg_ack` answers a request whose `reg_addr` is the command. `reg_req` and `reg_addr` hold until `reg_ack`.
- R7: After the master does not acknowledge a returned byte, SDA stays released until a STOP or START.
- R8: A STOP empties the queue.
- R9: When no stored command remains, a byte read by the master is 0xFF.
- R10: A pulse of one clock cycle on SCL or on SDA is ignored.
- R11: During and right after reset, `sda_oe` and `reg_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | When high, pulls SDA low |
| reg_req | output | 1 | Register read request |
| reg_addr | output | 8 | Command byte used as register address |
| reg_ack | input | 1 | Register read completion |
| reg_data | input | 8 | Register value, valid with `reg_ack` |

## Verification
The echo path is tested with one, two and three commands per transaction.

- Values 0x00, 0xFF and alternating bit patterns expose bit-order and shift errors.
- A repeated identical command shows that every entry is dequeued separately rather than merged.
- Each data byte is a fixed function of its command, so a data byte paired with the wrong command is visible at once.
- Ten commands in one write separate the acknowledge limit from queue wrap-around.
- Reads after a STOP and past the end of the queue show the 0xFF fill.
- A wrong address shows the slave staying silent.
- Single-cycle glitches on both lines, placed while SCL is high, show whether the filter stops false clocks and false START or STOP conditions.

// File: rtl/cmd_echo_i2c_slave.sv
module cmd_echo_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter int QDEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       reg_req,
  output logic [7:0] reg_addr,
  input  logic       reg_ack,
  input  logic [7:0] reg_data
);
  localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_CACK, S_TX, S_TXACK, S_WAIT} st_t;

  logic [2:0] scl_sy, sda_sy;
  logic scl_f, sda_f, scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh, dat_q;
  logic rw_q, mack, phase;
  logic [CW-1:0] wr_cnt, rd_ptr;
  logic [7:0] q_mem [QDEPTH];

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  wire full     = (wr_cnt == CW'(QDEPTH));
  wire q_has    = (rd_ptr != wr_cnt);
  wire take_cmd = (st == S_AACK) || !phase;
  wire [7:0] head = q_mem[rd_ptr[IW-1:0]];
  wire [7:0] nxt_byte = !take_cmd ? dat_q : (q_has ? head : 8'hFF);
  wire ev_ok    = !start_c && !stop_c;
  wire push     = ev_ok && (st == S_RX) && scl_fall && (cnt == 4'd8) && !full;
  wire do_load  = ev_ok && scl_fall &&
                  (((st == S_AACK) && rw_q) || ((st == S_TXACK) && mack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      if (scl_sy[2] == scl_sy[1]) scl_f <= scl_sy[2];
      if (sda_sy[2] == sda_sy[1]) sda_f <= sda_sy[2];
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_ff @(posedge clk) if (push) q_mem[wr_cnt[IW-1:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; dat_q <= '0;
      rw_q <= 1'b0; mack <= 1'b0; phase <= 1'b0;
      wr_cnt <= '0; rd_ptr <= '0;
      sda_oe <= 1'b0; reg_req <= 1'b0; reg_addr <= '0;
    end else begin
      if (reg_req && reg_ack) begin
        reg_req <= 1'b0;
        dat_q <= reg_data;
      end
      if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; wr_cnt <= '0; rd_ptr <= '0;
      end else if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1; rw_q <= sh[0]; st <= S_AACK;
                end else begin
                  st <= S_IDLE; wr_cnt <= '0; rd_ptr <= '0;
                end
              end else begin
                if (!full) begin
                  sda_oe <= 1'b1;
                  wr_cnt <= wr_cnt + CW'(1);
                end
                st <= S_CACK;
              end
            end
          end
          S_AACK: if (scl_fall && !rw_q) begin
            sda_oe <= 1'b0; cnt <= '0; st <= S_RX;
          end
          S_CACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0; st <= S_RX;
          end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= S_TXACK;
            end else begin
              sda_oe <= ~sh[7];
              sh <= {sh[6:0], 1'b1};
              cnt <= cnt + 4'd1;
            end
          end
          S_TXACK: begin
            if (scl_rise) mack <= ~sda_f;
            if (scl_fall && !mack) begin
              sda_oe <= 1'b0; st <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
      if (do_load) begin
        sh <= {nxt_byte[6:0], 1'b1};
        sda_oe <= ~nxt_byte[7];
        cnt <= '0;
        st <= S_TX;
        if (take_cmd && q_has) begin
          reg_addr <= head;
          reg_req <= 1'b1;
          rd_ptr <= rd_ptr + CW'(1);
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_echo_i2c_chk.sv
module cmd_echo_i2c_chk #(
  parameter int QDEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_f,
  input logic          reg_req,
  input logic          reg_ack,
  input logic [7:0]    reg_addr,
  input logic [CW-1:0] wr_cnt,
  input logic [CW-1:0] rd_ptr
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req);
  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> $stable(reg_addr));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= CW'(QDEPTH));
  // R5
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= wr_cnt);
  // R5
  sda_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f);
endmodule

bind cmd_echo_i2c_slave cmd_echo_i2c_chk #(.QDEPTH(QDEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f),
  .reg_req(reg_req), .reg_ack(reg_ack), .reg_addr(reg_addr),
  .wr_cnt(wr_cnt), .rd_ptr(rd_ptr)
);

// File: tb/sim_cmd_echo_i2c_slave.sv
module sim_cmd_echo_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h24;
  localparam logic [7:0] AR = 8'h25;
  localparam logic [31:0] VEC [4] = '{
    {8'd1, 8'h3C, 8'h00, 8'h00},
    {8'd3, 8'h01, 8'h80, 8'h7E},
    {8'd2, 8'h00, 8'hFF, 8'h00},
    {8'd3, 8'h55, 8'h55, 8'hAA}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, glitch = 1'b0;
  logic sda_oe, reg_req, reg_ack = 1'b0;
  logic [7:0] reg_addr, reg_data = '0;
  wire sda_bus = sda_m & ~sda_oe;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_echo_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_req(reg_req), .reg_addr(reg_addr), .reg_ack(reg_ack), .reg_data(reg_data)
  );

  initial forever begin
    @(negedge clk);
    reg_ack = 1'b0;
    if (reg_req) begin
      repeat (3) @(negedge clk);
      reg_data = reg_addr ^ 8'hA5;
      reg_ack = 1'b1;
      @(negedge clk);
      reg_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(Q);
    if (glitch) begin
      scl = 1'b0; wq(1); scl = 1'b1;
      sda_m = ~b; wq(1); sda_m = b;
    end
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic rd_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(x);
    ack = ~x;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(x);
      v[i] = x;
    end
    wr_bit(~mack);
  endtask

  initial begin
    logic ack;
    logic [7:0] v, c;
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(sda_oe == 1'b0 && reg_req == 1'b0, "R11", {sda_oe, reg_req}, 0);
    rst_n = 1'b1;
    wq(5);
    chk(sda_oe == 1'b0 && reg_req == 1'b0, "R11", {sda_oe, reg_req}, 0);

    for (int k = 0; k < 4; k++) begin
      n = int'(VEC[k][31:24]);
      bus_start();
      wr_byte(AW, ack); chk(ack, "R1", ack, 1);
      for (int i = 0; i < n; i++) begin
        wr_byte(VEC[k][23-8*i -: 8], ack);
        chk(ack, "R2", ack, 1);
      end
      bus_start();
      wr_byte(AR, ack); chk(ack, "R4", ack, 1);
      for (int i = 0; i < n; i++) begin
        c = VEC[k][23-8*i -: 8];
        rd_byte(1'b1, v); chk(v == c, "R5", v, c);
        rd_byte(i != n-1, v); chk(v == (c ^ 8'hA5), "R6", v, c ^ 8'hA5);
      end
      bus_stop();
    end

    // R1 wrong address is ignored
    bus_start();
    wr_byte(8'h26, ack); chk(!ack, "R1", ack, 0);
    wr_byte(8'h11, ack); chk(!ack, "R1", ack, 0);
    bus_stop();

    // R2 R3 ten commands, eight accepted
    bus_start();
    wr_byte(AW, ack);
    for (int i = 0; i < 10; i++) begin
      wr_byte(8'h10 + 8'(i), ack);
      if (i < 8) chk(ack, "R2", ack, 1);
      else chk(!ack, "R3", ack, 0);
    end
    bus_start();
    wr_byte(AR, ack); chk(ack, "R4", ack, 1);
    for (int i = 0; i < 8; i++) begin
      c = 8'h10 + 8'(i);
      rd_byte(1'b1, v); chk(v == c, "R3", v, c);
      rd_byte(i != 7, v); chk(v == (c ^ 8'hA5), "R6", v, c ^ 8'hA5);
    end
    // R7 released after master NAK
    rd_byte(1'b0, v); chk(v == 8'hFF, "R7", v, 8'hFF);
    bus_stop();

    // R9 reading past the last pair
    bus_start();
    wr_byte(AW, ack); wr_byte(8'hC3, ack);
    bus_start();
    wr_byte(AR, ack);
    rd_byte(1'b1, v); chk(v == 8'hC3, "R5", v, 8'hC3);
    rd_byte(1'b1, v); chk(v == 8'h66, "R6", v, 8'h66);
    rd_byte(1'b0, v); chk(v == 8'hFF, "R9", v, 8'hFF);
    bus_stop();

    // R8 STOP clears the queue
    bus_start();
    wr_byte(AW, ack); wr_byte(8'h42, ack); wr_byte(8'h43, ack);
    bus_stop();
    bus_start();
    wr_byte(AR, ack); chk(ack, "R4", ack, 1);
    rd_byte(1'b0, v); chk(v == 8'hFF, "R8", v, 8'hFF);
    bus_stop();

    // R10 one-cycle glitches on both lines
    bus_start();
    glitch = 1'b1;
    wr_byte(AW, ack); chk(ack, "R10", ack, 1);
    wr_byte(8'h96, ack); chk(ack, "R10", ack, 1);
    glitch = 1'b0;
    bus_start();
    wr_byte(AR, ack);
    rd_byte(1'b1, v); chk(v == 8'h96, "R10", v, 8'h96);
    rd_byte(1'b0, v); chk(v == 8'h33, "R10", v, 8'h33);
    bus_stop();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule